// File: doc/BRIEF.md
# Biresidue Syndrome Decoder and Accumulator Corrector

This block sits beside an accumulator guarded by two residue checkers, one working modulo 7 and one modulo 15. Each operation cycle the checkers deliver a pair of syndromes, and the accumulator delivers its result word. The block captures both syndrome parts and the word into holding registers. It then sorts the pair into one of five classes: no fault, fault in the modulo-7 checker, fault in the modulo-15 checker, a single-bit accumulator fault, or a pattern that cannot be corrected.

A single-bit accumulator fault adds either plus or minus a power of two to the 12-bit word. Each of the 24 possible faults leaves a syndrome pair that no other fault shares. The block turns that pair back into a bit index and a sign. It removes the fault with one's complement arithmetic modulo 4095 and presents the repaired word. A checker fault leaves the word as it is and raises a sticky lockout. The lockout suppresses every later repair until a maintenance clear arrives.

Top module: `brc_syndrome_corrector`

## Requirements
- R1: A pulse on `syn_valid` captures `syn_a`, `syn_b` and `acc_in`. Exactly two rising clock edges later, `out_valid` is high for one cycle with the decoded result.
- R2: A syndrome part counts as zero only when all of its bits are zero. The pair (0,0) gives class 0 (none), and `out_word` equals the captured word.
- R3: A nonzero `syn_a` with a zero `syn_b` gives class 1 (modulo-7 checker fault). A zero `syn_a` with a nonzero `syn_b` gives class 2 (modulo-15 checker fault). In both cases the word passes unchanged.
- R4: The pair (2^(j mod 3), 2^(j mod 4)) for j in 0..11 gives class 3 (accumulator), `out_idx` = j and `out_neg` = 0.
- R5: The pair (7 - 2^(j mod 3), 15 - 2^(j mod 4)) for j in 0..11 gives class 3, `out_idx` = j and `out_neg` = 1.
- R6: For class 3 with no lockout, `out_word` is the captured word minus the signed fault value, modulo 4095, using end-around carry. The bench checks this against nonzero original words.
- R7: Both parts nonzero but matching none of the 24 pairs gives class 4 (uncorrectable). The word passes unchanged.
- R8: A result of class 1 or 2 sets `inhibit` in the same cycle its `out_valid` is high. `inhibit` then stays set.
- R9: While `inhibit` is set, a class-3 result still reports its index and sign, but `out_word` equals the captured word.
- R10: `maint_clr` clears `inhibit` on the next edge. If a checker-class result lands on that same edge, `inhibit` stays set.
- R11: After reset, all outputs are zero. For every class other than 3, `out_idx` and `out_neg` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| syn_valid | input | 1 | Capture strobe for syndromes and word |
| syn_a | input | 3 | Syndrome part, modulo 7 |
| syn_b | input | 4 | Syndrome part, modulo 15 |
| acc_in | input | 12 | Accumulator result word as computed |
| maint_clr | input | 1 | Maintenance clear of the lockout |
| out_valid | output | 1 | One-cycle result strobe |
| out_word | output | 12 | Repaired or passed-through word |
| out_class | output | 3 | Fault class code 0..4 |
| out_idx | output | 4 | Faulty bit index for class 3 |
| out_neg | output | 1 | Fault sign for class 3 (1 = minus) |
| inhibit | output | 1 | Sticky repair lockout |

## Verification
Two actions can fall on the same clock edge: a maintenance clear of the lockout, and the decode of a new checker fault that sets it. The bench times a `maint_clr` pulse to land on the edge where a checker-class result is registered. It expects the lockout still set afterwards. A lone clear must then release it. The bench also follows a lockout with an accumulator fault and checks that the index and sign are reported while the word stays unrepaired.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_CHK_A  = 3'd1,
    CLS_CHK_B  = 3'd2,
    CLS_ACC    = 3'd3,
    CLS_UNCORR = 3'd4
  } err_class_e;
endpackage

// File: rtl/brc_syn_regs.sv
// Holding registers for both syndrome parts and the accumulator word.
module brc_syn_regs #(
  parameter int A_W   = 3,
  parameter int B_W   = 4,
  parameter int ACC_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [A_W-1:0]   sa_in,
  input  logic [B_W-1:0]   sb_in,
  input  logic [ACC_W-1:0] acc_d,
  output logic             held_valid,
  output logic [A_W-1:0]   sa_q,
  output logic [B_W-1:0]   sb_q,
  output logic [ACC_W-1:0] acc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held_valid <= 1'b0;
      sa_q       <= '0;
      sb_q       <= '0;
      acc_q      <= '0;
    end else begin
      held_valid <= load;
      if (load) begin
        sa_q  <= sa_in;
        sb_q  <= sb_in;
        acc_q <= acc_d;
      end
    end
  end
endmodule

// File: rtl/brc_syn_lookup.sv
// Matches a syndrome pair against every signed single-bit fault.
module brc_syn_lookup #(
  parameter int A_W   = 3,
  parameter int B_W   = 4,
  parameter int ACC_W = 12,
  parameter int IDX_W = $clog2(ACC_W)
) (
  input  logic [A_W-1:0]   sa,
  input  logic [B_W-1:0]   sb,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic             neg
);
  localparam int MOD_A = (1 << A_W) - 1;
  localparam int MOD_B = (1 << B_W) - 1;

  logic [ACC_W-1:0] pos_hit;
  logic [ACC_W-1:0] neg_hit;

  for (genvar j = 0; j < ACC_W; j++) begin : g_bit
    localparam int PA = 1 << (j % A_W);
    localparam int PB = 1 << (j % B_W);
    localparam logic [A_W-1:0] POS_A = A_W'(PA);
    localparam logic [B_W-1:0] POS_B = B_W'(PB);
    localparam logic [A_W-1:0] NEG_A = A_W'(MOD_A - PA);
    localparam logic [B_W-1:0] NEG_B = B_W'(MOD_B - PB);
    assign pos_hit[j] = (sa == POS_A) && (sb == POS_B);
    assign neg_hit[j] = (sa == NEG_A) && (sb == NEG_B);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    neg = 1'b0;
    for (int k = 0; k < ACC_W; k++) begin
      if (pos_hit[k] || neg_hit[k]) begin
        hit = 1'b1;
        idx = IDX_W'(k);
        neg = neg_hit[k];
      end
    end
  end
endmodule

// File: rtl/brc_ones_fix.sv
// Removes a signed power-of-two fault modulo 2^W-1 (end-around carry).
module brc_ones_fix #(
  parameter int W     = 12,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     word,
  input  logic [IDX_W-1:0] idx,
  input  logic             neg,
  output logic [W-1:0]     fixed
);
  logic [W-1:0] mag;
  logic [W-1:0] operand;
  logic [W:0]   sum;

  always_comb begin
    mag     = W'(1) << idx;
    // A minus fault is removed by adding the magnitude; a plus fault by
    // adding its one's complement.
    operand = neg ? mag : ~mag;
    sum     = {1'b0, word} + {1'b0, operand};
    fixed   = sum[W-1:0] + W'(sum[W]);
  end
endmodule

// File: rtl/brc_syndrome_corrector.sv
module brc_syndrome_corrector #(
  parameter int A_W   = 3,
  parameter int B_W   = 4,
  parameter int ACC_W = 12,
  parameter int IDX_W = $clog2(ACC_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             syn_valid,
  input  logic [A_W-1:0]   syn_a,
  input  logic [B_W-1:0]   syn_b,
  input  logic [ACC_W-1:0] acc_in,
  input  logic             maint_clr,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_word,
  output logic [2:0]       out_class,
  output logic [IDX_W-1:0] out_idx,
  output logic             out_neg,
  output logic             inhibit
);
  import brc_pkg::*;

  logic             held_valid;
  logic [A_W-1:0]   sra_q;
  logic [B_W-1:0]   srb_q;
  logic [ACC_W-1:0] acc_q;
  logic             lk_hit;
  logic [IDX_W-1:0] lk_idx;
  logic             lk_neg;
  logic [ACC_W-1:0] fixed_word;
  err_class_e       cls;
  logic             chk_fault;

  brc_syn_regs #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W)) u_regs (
    .clk(clk), .rst(rst), .load(syn_valid),
    .sa_in(syn_a), .sb_in(syn_b), .acc_d(acc_in),
    .held_valid(held_valid), .sa_q(sra_q), .sb_q(srb_q), .acc_q(acc_q)
  );

  brc_syn_lookup #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_lookup (
    .sa(sra_q), .sb(srb_q), .hit(lk_hit), .idx(lk_idx), .neg(lk_neg)
  );

  brc_ones_fix #(.W(ACC_W), .IDX_W(IDX_W)) u_fix (
    .word(acc_q), .idx(lk_idx), .neg(lk_neg), .fixed(fixed_word)
  );

  always_comb begin
    if (~|sra_q && ~|srb_q)  cls = CLS_NONE;
    else if (~|srb_q)        cls = CLS_CHK_A;
    else if (~|sra_q)        cls = CLS_CHK_B;
    else if (lk_hit)         cls = CLS_ACC;
    else                     cls = CLS_UNCORR;
    chk_fault = held_valid && (cls == CLS_CHK_A || cls == CLS_CHK_B);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_class <= '0;
      out_idx   <= '0;
      out_neg   <= 1'b0;
      inhibit   <= 1'b0;
    end else begin
      out_valid <= held_valid;
      if (held_valid) begin
        out_class <= cls;
        out_word  <= (cls == CLS_ACC && !inhibit) ? fixed_word : acc_q;
        out_idx   <= (cls == CLS_ACC) ? lk_idx : '0;
        out_neg   <= (cls == CLS_ACC) && lk_neg;
      end
      // A new checker fault outranks a maintenance clear on the same edge.
      if (chk_fault)      inhibit <= 1'b1;
      else if (maint_clr) inhibit <= 1'b0;
    end
  end
endmodule

// File: rtl/brc_syndrome_corrector_chk.sv
module brc_syndrome_corrector_chk #(
  parameter int ACC_W = 12,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             syn_valid,
  input logic [ACC_W-1:0] acc_in,
  input logic             maint_clr,
  input logic             out_valid,
  input logic [ACC_W-1:0] out_word,
  input logic [2:0]       out_class,
  input logic [IDX_W-1:0] out_idx,
  input logic             out_neg,
  input logic             inhibit
);
  // R1
  latency_two_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(syn_valid, 2));
  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class != 3'd3) |-> out_word == $past(acc_in, 2));
  // R8
  lock_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(inhibit) |-> (out_valid && (out_class == 3'd1 || out_class == 3'd2)));
  // R9
  locked_no_fix_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == 3'd3 && $past(inhibit)) |-> out_word == $past(acc_in, 2));
  // R10
  lock_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(inhibit) |-> $past(maint_clr));
  // R11
  class_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_class <= 3'd4 && (out_class == 3'd3 || (out_idx == '0 && !out_neg))));
endmodule

bind brc_syndrome_corrector brc_syndrome_corrector_chk #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .syn_valid(syn_valid), .acc_in(acc_in), .maint_clr(maint_clr),
  .out_valid(out_valid), .out_word(out_word), .out_class(out_class),
  .out_idx(out_idx), .out_neg(out_neg), .inhibit(inhibit)
);

// File: tb/tb_brc_syndrome_corrector.sv
module tb_brc_syndrome_corrector;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        syn_valid = 1'b0;
  logic [2:0]  syn_a = '0;
  logic [3:0]  syn_b = '0;
  logic [11:0] acc_in = '0;
  logic        maint_clr = 1'b0;
  logic        out_valid;
  logic [11:0] out_word;
  logic [2:0]  out_class;
  logic [3:0]  out_idx;
  logic        out_neg;
  logic        inhibit;
  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  brc_syndrome_corrector dut (
    .clk(clk), .rst(rst), .syn_valid(syn_valid), .syn_a(syn_a), .syn_b(syn_b),
    .acc_in(acc_in), .maint_clr(maint_clr), .out_valid(out_valid),
    .out_word(out_word), .out_class(out_class), .out_idx(out_idx),
    .out_neg(out_neg), .inhibit(inhibit)
  );

  // {sa, sb, acc, expected word, class, idx, neg}
  localparam logic [38:0] VEC [6] = '{
    {3'd0, 4'd0,  12'h5A3, 12'h5A3, 3'd0, 4'd0,  1'b0},  // R2
    {3'd3, 4'd5,  12'h123, 12'h123, 3'd4, 4'd0,  1'b0},  // R7
    {3'd6, 4'd9,  12'hABC, 12'hABC, 3'd4, 4'd0,  1'b0},  // R7
    {3'd1, 4'd1,  12'h800, 12'h7FF, 3'd3, 4'd0,  1'b0},  // R4 R6
    {3'd3, 4'd7,  12'h7FE, 12'hFFE, 3'd3, 4'd11, 1'b1},  // R5 R6
    {3'd4, 4'd8,  12'h900, 12'h100, 3'd3, 4'd11, 1'b0}   // R4 R6
  };

  task automatic cmp(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one capture, optionally clear on the decode edge, sample after it.
  task automatic apply(input logic [2:0] sa, input logic [3:0] sb,
                       input logic [11:0] acc, input logic clr_on_decode);
    @(negedge clk);
    syn_a = sa; syn_b = sb; acc_in = acc; syn_valid = 1'b1;
    @(negedge clk);
    syn_valid = 1'b0; maint_clr = clr_on_decode;
    @(negedge clk);
    maint_clr = 1'b0;
  endtask

  task automatic expect_out(input string req, input int word, input int cls,
                            input int idx, input int neg);
    cmp("R1", "valid", int'(out_valid), 1);
    cmp(req, "word", int'(out_word), word);
    cmp(req, "class", int'(out_class), cls);
    cmp(req, "idx", int'(out_idx), idx);
    cmp(req, "neg", int'(out_neg), neg);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    cmp("R11", "valid", int'(out_valid), 0);
    cmp("R11", "word", int'(out_word), 0);
    cmp("R11", "class", int'(out_class), 0);
    cmp("R11", "inhibit", int'(inhibit), 0);

    // Table walk
    for (int v = 0; v < 6; v++) begin
      apply(VEC[v][38:36], VEC[v][35:32], VEC[v][31:20], 1'b0);
      expect_out("R2R4R5R6R7", int'(VEC[v][19:8]), int'(VEC[v][7:5]),
                 int'(VEC[v][4:1]), int'(VEC[v][0]));
      @(negedge clk);
      cmp("R1", "valid drop", int'(out_valid), 0);
    end

    // Every signed single-bit fault: R4 R5 R6
    for (int j = 0; j < 12; j++) begin
      for (int s = 0; s < 2; s++) begin
        int x, xp, pa, pb, sa, sb;
        x  = 933 + 97 * j + 5 * s;
        pa = 1 << (j % 3);
        pb = 1 << (j % 4);
        if (s == 0) begin xp = (x + (1 << j)) % 4095;        sa = pa;     sb = pb;      end
        else        begin xp = (x + 4095 - (1 << j)) % 4095; sa = 7 - pa; sb = 15 - pb; end
        apply(3'(sa), 4'(sb), 12'(xp), 1'b0);
        expect_out(s == 0 ? "R4R6" : "R5R6", x, 3, j, s);
      end
    end
    cmp("R8", "inhibit idle", int'(inhibit), 0);

    // R3 R8 checker A fault sets lockout
    apply(3'd5, 4'd0, 12'h234, 1'b0);
    expect_out("R3", 12'h234, 1, 0, 0);
    cmp("R8", "inhibit set", int'(inhibit), 1);
    // R9 lockout keeps the accumulator word (j=1, plus)
    apply(3'd2, 4'd2, 12'h102, 1'b0);
    expect_out("R9", 12'h102, 3, 1, 0);
    cmp("R8", "inhibit held", int'(inhibit), 1);
    // R10 lone clear
    @(negedge clk); maint_clr = 1'b1;
    @(negedge clk); maint_clr = 1'b0;
    cmp("R10", "inhibit cleared", int'(inhibit), 0);
    apply(3'd2, 4'd2, 12'h102, 1'b0);
    expect_out("R6", 12'h100, 3, 1, 0);

    // R10 clear on the same edge as a checker B decode: set wins
    apply(3'd0, 4'd11, 12'h0F0, 1'b1);
    expect_out("R3", 12'h0F0, 2, 0, 0);
    cmp("R10", "set beats clear", int'(inhibit), 1);
    @(negedge clk); maint_clr = 1'b1;
    @(negedge clk); maint_clr = 1'b0;
    cmp("R10", "inhibit cleared again", int'(inhibit), 0);

    // R3 every checker fault value
    for (int a = 1; a < 8; a++) begin
      apply(3'(a), 4'd0, 12'(a * 37), 1'b0);
      expect_out("R3", a * 37, 1, 0, 0);
    end
    for (int b = 1; b < 16; b++) begin
      apply(3'd0, 4'(b), 12'(b * 53), 1'b0);
      expect_out("R3", b * 53, 2, 0, 0);
    end
    cmp("R8", "inhibit after sweep", int'(inhibit), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule